// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives one asynchronous serial channel. A falling edge on the synchronised line starts a frame. The frame is then collected bit by bit from a 16x oversampling tick: a start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit, and one or two stop bits. When the first stop bit has been sampled, the gathered byte moves from the shift register into the receive data register. Parity and framing are judged at that same moment.

Errors never stop reception. A byte with a parity fault, a bad stop bit or an overrun is still stored, and the receiver goes straight back to hunting for the next start bit. Each error leaves a sticky flag in the status byte. Software reads the data register with a one-cycle read strobe. It clears a flag by writing 0 to that flag's bit through a one-cycle status write strobe.

The frame controller is a state machine with these states:
- `RX_IDLE`: waits for a falling edge.
- `RX_START`: confirms the start bit at mid-bit.
- `RX_DATA`: samples the data bits.
- `RX_PAR`: samples the parity bit.
- `RX_STOP1`: samples the first stop bit and raises the transfer.
- `RX_STOP2`: waits out the second stop bit and ignores its value.

Transitions:
- IDLE→START on a falling edge while enabled.
- START→IDLE when the mid-bit sample is high (glitch).
- START→DATA when the mid-bit sample is low.
- DATA→PAR, or DATA→STOP1 when parity is off, after the last data bit.
- PAR→STOP1.
- STOP1→STOP2 in two-stop mode, otherwise STOP1→IDLE.
- STOP2→IDLE.
- Any state→IDLE when receive enable is low.

Top module: `async_rx_core`

## Requirements
- R1: After reset, `rx_data` reads 0x00 and `status` reads 0x00.
- R2: Data bits are taken least significant bit first. When `len7` is 1, seven bits are received and `rx_data[7]` reads 0. Otherwise eight bits are received.
- R3: `status[0]` (buffer full) becomes 1 when a byte is transferred into `rx_data`. It returns to 0 after a `rd_data` pulse.
- R4: With `par_en` set, a parity mismatch sets `status[3]`. Odd mode (`par_odd`=1) expects an odd count of ones over the data bits plus the parity bit. Even mode expects an even count. The byte is still stored.
- R5: A first stop bit sampled as 0 sets `status[4]`. The byte is still stored.
- R6: With `two_stop` set, a 0 in the second stop bit sets no flag.
- R7: When a byte is transferred while `status[0]` is already 1, `rx_data` takes the new byte and `status[2]` becomes 1.
- R8: A `wr_status` pulse clears each of `status[2]`, `status[3]` and `status[4]` whose bit in `wr_value` is 0. A bit written as 1 leaves its flag unchanged.
- R9: While `rx_en` is 0, nothing is received. A frame interrupted by `rx_en` going low changes neither `rx_data` nor `status`.
- R10: A start bit that reads high at its mid-bit sample is discarded, and no byte is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| rd_data | input | 1 | Read strobe for the data register |
| wr_status | input | 1 | Status write strobe |
| wr_value | input | 8 | Status write data (0 in bits 2..4 clears) |
| rx_data | output | 8 | Receive data register |
| status | output | 8 | bit0 full, bit2 overrun, bit3 parity, bit4 framing, others 0 |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, an 8-bit data register and a two-stage synchroniser. It drives the baud tick every second clock, so each bit lasts 32 clocks and the three-cycle input latency stays well inside the mid-bit sampling margin. These values bring within reach both data lengths, both parity senses, single and double stop bits, back-to-back frames that overrun the unread register, short glitches that are shorter than half a bit, and an enable drop part-way through a frame.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    localparam int STAT_W   = 8;
    localparam int BIT_FULL = 0;
    localparam int BIT_OVR  = 2;
    localparam int BIT_PAR  = 3;
    localparam int BIT_FRM  = 4;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
    import async_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_s,
    input  logic          baud_tick,
    input  logic          rx_en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    input  logic          len7,
    output logic          done,
    output logic [DW-1:0] done_data,
    output logic          done_perr,
    output logic          done_ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DW + 1);
    localparam int HALF = OVS / 2;

    rx_state_t        state, nxt;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    bit_idx, last_idx;
    logic [DW-1:0]    shreg;
    logic             par_bit, prev_s;
    logic             fall, samp_half, samp_full;

    assign fall      = prev_s && !rx_s;
    assign samp_half = baud_tick && (cnt == CW'(HALF - 1));
    assign samp_full = baud_tick && (cnt == CW'(OVS - 1));
    assign last_idx  = len7 ? IW'(DW - 2) : IW'(DW - 1);

    always_comb begin
        nxt = state;
        if (!rx_en) begin
            nxt = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:  if (fall) nxt = RX_START;
                RX_START: if (samp_half) nxt = rx_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (samp_full && bit_idx == last_idx)
                              nxt = par_en ? RX_PAR : RX_STOP1;
                RX_PAR:   if (samp_full) nxt = RX_STOP1;
                RX_STOP1: if (samp_full) nxt = two_stop ? RX_STOP2 : RX_IDLE;
                RX_STOP2: if (samp_full) nxt = RX_IDLE;
                default:  nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            prev_s    <= 1'b1;
            done      <= 1'b0;
            done_data <= '0;
            done_perr <= 1'b0;
            done_ferr <= 1'b0;
        end else begin
            prev_s <= rx_s;
            done   <= 1'b0;
            if (state != nxt || state == RX_IDLE || samp_full) cnt <= '0;
            else if (baud_tick)                                cnt <= cnt + 1'b1;

            if (state == RX_IDLE) begin
                bit_idx <= '0;
                shreg   <= '0;
                par_bit <= 1'b0;
            end
            if (rx_en && state == RX_DATA && samp_full) begin
                shreg   <= shreg | (DW'(rx_s) << bit_idx);
                bit_idx <= bit_idx + 1'b1;
            end
            if (rx_en && state == RX_PAR && samp_full) par_bit <= rx_s;
            if (rx_en && state == RX_STOP1 && samp_full) begin
                done      <= 1'b1;
                done_data <= shreg;
                done_ferr <= !rx_s;
                done_perr <= par_en && ((^shreg ^ par_bit) != par_odd);
            end
        end
    end

    // R9: a dropped enable returns the controller to idle on the next edge
    a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == RX_IDLE));
    // R10: a high mid-bit start sample never proceeds to data
    a_r10_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && samp_half && rx_s) |=> (state != RX_DATA));
    // R3: a transfer pulse lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/async_rx_regs.sv
module async_rx_regs
    import async_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DW-1:0]     xfer_data,
    input  logic              xfer_perr,
    input  logic              xfer_ferr,
    input  logic              rd_data,
    input  logic              wr_status,
    input  logic [STAT_W-1:0] wr_value,
    output logic [DW-1:0]     rx_data,
    output logic [STAT_W-1:0] status
);
    logic full_q, ovr_q, perr_q, ferr_q;
    logic clr_ovr, clr_par, clr_frm;

    assign clr_ovr = wr_status && !wr_value[BIT_OVR];
    assign clr_par = wr_status && !wr_value[BIT_PAR];
    assign clr_frm = wr_status && !wr_value[BIT_FRM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            if (xfer) rx_data <= xfer_data;
            full_q <= xfer || (full_q && !rd_data);
            ovr_q  <= (xfer && full_q && !rd_data) || (ovr_q && !clr_ovr);
            perr_q <= (xfer && xfer_perr) || (perr_q && !clr_par);
            ferr_q <= (xfer && xfer_ferr) || (ferr_q && !clr_frm);
        end
    end

    always_comb begin
        status           = '0;
        status[BIT_FULL] = full_q;
        status[BIT_OVR]  = ovr_q;
        status[BIT_PAR]  = perr_q;
        status[BIT_FRM]  = ferr_q;
    end

    // R3: a transfer leaves the buffer marked full
    a_r3_full_set: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> status[BIT_FULL]);
    // R7: a transfer onto an unread byte raises the overrun flag
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && status[BIT_FULL] && !rd_data) |=> status[BIT_OVR]);
    // R8: flags hold unless a 0 is written to their bit
    a_r8_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_PAR] && !(wr_status && !wr_value[BIT_PAR])) |=> status[BIT_PAR]);
    a_r8_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_FRM] && !(wr_status && !wr_value[BIT_FRM])) |=> status[BIT_FRM]);
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_OVR] && !(wr_status && !wr_value[BIT_OVR])) |=> status[BIT_OVR]);
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              len7,
    input  logic              rd_data,
    input  logic              wr_status,
    input  logic [STAT_W-1:0] wr_value,
    output logic [DW-1:0]     rx_data,
    output logic [STAT_W-1:0] status
);
    logic          rx_s, xfer, xfer_perr, xfer_ferr;
    logic [DW-1:0] xfer_data;

    async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    async_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_s     (rx_s),
        .baud_tick(baud_tick),
        .rx_en    (rx_en),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .len7     (len7),
        .done     (xfer),
        .done_data(xfer_data),
        .done_perr(xfer_perr),
        .done_ferr(xfer_ferr)
    );

    async_rx_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .xfer_data(xfer_data),
        .xfer_perr(xfer_perr),
        .xfer_ferr(xfer_ferr),
        .rd_data  (rd_data),
        .wr_status(wr_status),
        .wr_value (wr_value),
        .rx_data  (rx_data),
        .status   (status)
    );
endmodule

// File: tb/async_rx_core_test.sv
module async_rx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, len7 = 1'b0;
    logic       rd_data = 1'b0, wr_status = 1'b0;
    logic [7:0] wr_value = 8'h00;
    logic [7:0] rx_data, status;
    int checks = 0;
    int errors = 0;

    localparam int BITC = 32;

    always #5 clk = ~clk;
    always @(posedge clk) baud_tick <= ~baud_tick;

    async_rx_core uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .len7(len7), .rd_data(rd_data), .wr_status(wr_status), .wr_value(wr_value),
        .rx_data(rx_data), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rx_in = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic l7, input logic has_par,
                              input logic pbit, input logic s1, input logic dbl, input logic s2);
        drive_bit(1'b0);
        for (int i = 0; i < (l7 ? 7 : 8); i++) drive_bit(d[i]);
        if (has_par) drive_bit(pbit);
        drive_bit(s1);
        if (dbl) drive_bit(s2);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    function automatic logic good_par(input logic [7:0] d, input logic l7, input logic odd);
        logic [7:0] m;
        m = l7 ? (d & 8'h7F) : d;
        return odd ? ~(^m) : (^m);
    endfunction

    task automatic do_read();
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_value = v; wr_status = 1'b1; @(negedge clk); wr_status = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data after reset", rx_data, 8'h00);
        chk("R1 status after reset", status, 8'h00);
    endtask

    task automatic t_basic();
        rx_en = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R2 8-bit data", rx_data, 8'hA5);
        chk("R3 full set", status, 8'h01);
        do_read();
        chk("R3 full cleared by read", status, 8'h00);
        len7 = 1'b1;
        send_frame(8'hD3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R2 7-bit data", rx_data, 8'h53);
        do_read();
        len7 = 1'b0;
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b1, good_par(8'h3C, 1'b0, 1'b1), 1'b1, 1'b0, 1'b1);
        chk("R4 odd parity correct", status, 8'h01);
        do_read();
        par_odd = 1'b0;
        send_frame(8'h81, 1'b0, 1'b1, ~good_par(8'h81, 1'b0, 1'b0), 1'b1, 1'b0, 1'b1);
        chk("R4 even parity error data kept", rx_data, 8'h81);
        chk("R4 even parity error flag", status, 8'h09);
        do_write(8'hF7);
        chk("R8 parity flag cleared by 0", status, 8'h01);
        do_read();
        len7 = 1'b1; par_odd = 1'b1;
        send_frame(8'h07, 1'b1, 1'b1, ~good_par(8'h07, 1'b1, 1'b1), 1'b1, 1'b0, 1'b1);
        chk("R4 odd parity error 7-bit", status, 8'h09);
        do_write(8'h00); do_read();
        len7 = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 framing data kept", rx_data, 8'h5A);
        chk("R5 framing flag", status, 8'h11);
        do_write(8'h00);
        chk("R8 clear all flags", status, 8'h01);
        do_read();
    endtask

    task automatic t_two_stop();
        two_stop = 1'b1;
        send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 second stop ignored data", rx_data, 8'h77);
        chk("R6 second stop ignored flag", status, 8'h01);
        do_read();
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 first stop checked", status, 8'h11);
        do_write(8'h00); do_read();
        two_stop = 1'b0;
    endtask

    task automatic t_overrun();
        send_frame(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        send_frame(8'h34, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R7 overwritten data", rx_data, 8'h34);
        chk("R7 overrun flag", status, 8'h05);
        do_write(8'hFF);
        chk("R8 write 1 no effect", status, 8'h05);
        do_write(8'hFB);
        chk("R8 overrun cleared", status, 8'h01);
        do_read();
        chk("R3 empty after read", status, 8'h00);
    endtask

    task automatic t_disable();
        rx_en = 1'b0;
        send_frame(8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9 disabled data unchanged", rx_data, 8'h34);
        chk("R9 disabled status", status, 8'h00);
        rx_en = 1'b1;
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0);
        rx_en = 1'b0;
        rx_in = 1'b1;
        repeat (400) @(negedge clk);
        rx_en = 1'b1;
        repeat (400) @(negedge clk);
        chk("R9 abandoned frame data", rx_data, 8'h34);
        chk("R9 abandoned frame status", status, 8'h00);
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (400) @(negedge clk);
        chk("R10 glitch no transfer", status, 8'h00);
        chk("R10 glitch data unchanged", rx_data, 8'h34);
        send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 receives after glitch", rx_data, 8'h66);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_parity();
        t_framing();
        t_two_stop();
        t_overrun();
        t_disable();
        t_glitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule